// File: doc/BRIEF.md
# Half-Duplex Jamming Backpressure Controller

This block holds off incoming traffic on a shared half-duplex medium by occupying it. While backpressure is switched on and the link is half-duplex, it keeps the byte-wide transmit data path busy with a steady alternating-bit pattern. Other stations then either defer or collide, so no new frames arrive.

When the host asks to send a frame, the controller lets the pattern byte that is under way finish. It then keeps the medium quiet for a programmable inter-packet gap and grants the medium to the frame transmitter. The grant ends when the transmitter reports that the frame completed or was aborted. The controller then goes back to jamming if backpressure is still on, or to silence if it is not.

The frame transmitter, collision handling and backoff sit outside this block. They appear only as the grant output and the done and abort inputs. One jam or gap byte lasts `BYTE_CYCLES` clocks.

Top module: `hdx_jam_ctrl`

## Requirements
- R1: After reset the block is idle, with `state_o` = 0, `tx_valid_o` = 0, `tx_data_o` = 0 and `frame_go_o` = 0.
- R2: If the block is idle with `fc_en_i` = 1, `full_duplex_i` = 0 and no request pending, it enters the jam state one clock later. Throughout the jam state `tx_valid_o` = 1 and `tx_data_o` = 8'h55.
- R3: A one-cycle pulse on `tx_req_i` is latched. If the block is jamming, it leaves the jam state only at the end of the current byte, so the length of every jam run is a whole multiple of `BYTE_CYCLES`. It then enters the gap state.
- R4: The gap state lasts `gap_len_i` × `BYTE_CYCLES` clocks, using the value sampled when the gap begins. A value of 0 is treated as 1. The frame state follows the gap.
- R5: In the frame state `frame_go_o` = 1 until `frame_done_i` is seen. On the next clock the block is in the jam state if `fc_en_i` = 1 and `full_duplex_i` = 0, and idle otherwise.
- R6: `frame_abort_i` ends the frame state exactly as `frame_done_i` does.
- R7: If `fc_en_i` is cleared during a jam byte, the jam state continues until that byte has run its full `BYTE_CYCLES` clocks. The block then goes idle with `tx_valid_o` = 0.
- R8: While `full_duplex_i` = 1 the block never enters the jam state, whatever `fc_en_i` is. Requests are still served through the gap and the frame.
- R9: A request that arrives while idle moves the block to the gap state one clock later, with no jam state in between. If jamming is off, the block returns to idle after the frame.
- R10: `state_o` encodes the state as 0 = idle, 1 = jam, 2 = gap and 3 = frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en_i | input | 1 | Backpressure (jamming) enable |
| full_duplex_i | input | 1 | Link is full-duplex; jamming is suppressed |
| gap_len_i | input | GAP_W | Inter-packet gap in byte times (0 means 1) |
| tx_req_i | input | 1 | Host frame request pulse |
| frame_done_i | input | 1 | Frame transmitter finished the frame |
| frame_abort_i | input | 1 | Frame transmitter abandoned the frame |
| tx_data_o | output | 8 | Jam byte on the medium (0 when not jamming) |
| tx_valid_o | output | 1 | Jam byte is being driven |
| frame_go_o | output | 1 | Medium granted to the frame transmitter |
| state_o | output | 2 | Current state (encoding in R10) |

## Verification
Every output is registered. A change of state seen at a rising edge is therefore sampled on the following falling edge: one clock after an idle request, an enable, a done or an abort. A jam run can only end on a byte boundary, and a gap lasts exactly `gap_len_i` × `BYTE_CYCLES` clocks. The bench measures these durations by counting falling-edge samples while `state_o` holds a value, and compares each count with the figure the requirement gives. A behavioural reference model advances on each rising edge and is compared with every output on each falling edge, so a change that comes a cycle early or late is caught in the cycle where it happens.

// File: rtl/hdx_jam_pkg.sv
package hdx_jam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JAM   = 2'd1,
        ST_GAP   = 2'd2,
        ST_FRAME = 2'd3
    } jam_state_e;

    localparam logic [7:0] JAM_PATTERN = 8'h55;
endpackage

// File: rtl/hdx_jam_byte_tick.sv
module hdx_jam_byte_tick #(
    parameter int BYTE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic byte_last
);
    localparam int CW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign byte_last = run && (cnt_q == LAST);

    always_comb begin
        if (!run || byte_last) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the position inside a byte never runs past the last clock of the byte
    assert_byte_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R3: a clock that is not the last of its byte is followed by the next position
    assert_byte_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byte_last) |=> (cnt_q != '0));
endmodule

// File: rtl/hdx_jam_gap_cnt.sv
module hdx_jam_gap_cnt #(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    assign done = tick && (cnt_q == GAP_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load)                       cnt_d = (load_val == '0) ? GAP_W'(1) : load_val;
        else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: byte ticks only reach the counter after a gap has been loaded
    assert_gap_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q != '0));
    // R4: a load always leaves at least one byte time to wait
    assert_gap_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));
endmodule

// File: rtl/hdx_jam_ctrl.sv
module hdx_jam_ctrl
    import hdx_jam_pkg::*;
#(
    parameter int BYTE_CYCLES = 4,
    parameter int GAP_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en_i,
    input  logic             full_duplex_i,
    input  logic [GAP_W-1:0] gap_len_i,
    input  logic             tx_req_i,
    input  logic             frame_done_i,
    input  logic             frame_abort_i,
    output logic [7:0]       tx_data_o,
    output logic             tx_valid_o,
    output logic             frame_go_o,
    output logic [1:0]       state_o
);
    typedef struct packed {
        jam_state_e state;
        logic       pend;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic byte_last, gap_done, gap_load, jam_ok, req_any, frame_end, in_byte;

    assign in_byte   = (ctrl_q.state == ST_JAM) || (ctrl_q.state == ST_GAP);
    assign jam_ok    = fc_en_i && !full_duplex_i;
    assign req_any   = ctrl_q.pend || tx_req_i;
    assign frame_end = frame_done_i || frame_abort_i;

    hdx_jam_byte_tick #(.BYTE_CYCLES(BYTE_CYCLES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_byte),
        .byte_last (byte_last)
    );

    hdx_jam_gap_cnt #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_len_i),
        .tick     (byte_last && (ctrl_q.state == ST_GAP)),
        .done     (gap_done)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_any)     ctrl_d.state = ST_GAP;
                else if (jam_ok) ctrl_d.state = ST_JAM;
            end
            ST_JAM: begin
                if (byte_last) begin
                    if (req_any)      ctrl_d.state = ST_GAP;
                    else if (!jam_ok) ctrl_d.state = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (gap_done) ctrl_d.state = ST_FRAME;
            end
            ST_FRAME: begin
                if (frame_end) ctrl_d.state = jam_ok ? ST_JAM : ST_IDLE;
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
        gap_load    = (ctrl_d.state == ST_GAP) && (ctrl_q.state != ST_GAP);
        ctrl_d.pend = gap_load ? 1'b0 : req_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.pend  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign tx_valid_o = (ctrl_q.state == ST_JAM);
    assign tx_data_o  = (ctrl_q.state == ST_JAM) ? JAM_PATTERN : 8'h00;
    assign frame_go_o = (ctrl_q.state == ST_FRAME);
    assign state_o    = ctrl_q.state;

    // R3/R7: a jam byte is never cut short
    assert_whole_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_JAM && !byte_last) |=> (ctrl_q.state == ST_JAM));
    // R5/R6: the grant holds until the transmitter reports an end
    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_FRAME && !frame_end) |=> (ctrl_q.state == ST_FRAME));
    // R9: idle never jumps straight to the frame
    assert_idle_no_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) |=> (ctrl_q.state != ST_FRAME));
    // R8: full-duplex keeps the jam state from being entered
    assert_fd_no_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state != ST_JAM && full_duplex_i) |=> (ctrl_q.state != ST_JAM));
    // R4: the frame is only reached through the gap
    assert_frame_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_go_o) |-> ($past(ctrl_q.state) == ST_GAP));
endmodule

// File: tb/hdx_jam_ctrl_test.sv
module hdx_jam_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int B = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, fd = 1'b0, req = 1'b0, done = 1'b0, abort = 1'b0;
    logic [6:0] gap = 7'd0;
    logic [7:0] tx_data;
    logic       tx_valid, frame_go;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_jam_ctrl #(.BYTE_CYCLES(B), .GAP_W(7)) uut (
        .clk(clk), .rst_n(rst_n), .fc_en_i(en), .full_duplex_i(fd),
        .gap_len_i(gap), .tx_req_i(req), .frame_done_i(done),
        .frame_abort_i(abort), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
        .frame_go_o(frame_go), .state_o(state)
    );

    // behavioural reference model
    int m_st = 0, m_cyc = 0, m_gap = 0;
    bit m_pend = 0;
    int ns;
    bit ra, ok, lastb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_cyc <= 0; m_gap <= 0; m_pend <= 0;
        end else begin
            ra    = m_pend || req;
            ok    = en && !fd;
            lastb = (m_st == 1 || m_st == 2) && (m_cyc == B - 1);
            ns    = m_st;
            if (m_st == 0) begin
                if (ra) ns = 2; else if (ok) ns = 1;
            end else if (m_st == 1) begin
                if (lastb) begin
                    if (ra) ns = 2; else if (!ok) ns = 0;
                end
            end else if (m_st == 2) begin
                if (lastb && m_gap == 1) ns = 3;
            end else begin
                if (done || abort) ns = ok ? 1 : 0;
            end
            m_cyc <= ((m_st == 1 || m_st == 2) && !lastb) ? m_cyc + 1 : 0;
            if (ns == 2 && m_st != 2) m_gap <= (gap == 0) ? 1 : int'(gap);
            else if (m_st == 2 && lastb) m_gap <= m_gap - 1;
            m_pend <= (ns == 2 && m_st != 2) ? 1'b0 : ra;
            m_st <= ns;
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(state) == m_st, "R10 model state", int'(state), m_st);
            chk(tx_valid == (m_st == 1) && tx_data == ((m_st == 1) ? 8'h55 : 8'h00)
                && frame_go == (m_st == 3), "R2 model outputs",
                {tx_valid, frame_go, tx_data}, m_st);
        end
        wd++;
        if (wd > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 50000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_while(input int s, output int n);
        n = 0;
        while (int'(state) == s && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_req();
        req = 1'b1; @(negedge clk); req = 1'b0;
    endtask

    initial begin
        int n;
        int total;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(state == 2'd0 && !tx_valid && !frame_go && tx_data == 8'h00, "R1 reset",
            int'(state), 0);

        gap = 7'd3; en = 1'b1;
        step(1);
        chk(state == 2'd1, "R2 jam entry", int'(state), 1);
        chk(tx_valid && tx_data == 8'h55, "R2 jam byte", int'(tx_data), 'h55);
        step(5);
        pulse_req();
        count_while(1, n);
        total = 6 + n;
        chk(total % B == 0, "R3 jam run whole bytes", total, (total / B) * B);
        chk(state == 2'd2, "R3 gap after jam", int'(state), 2);
        count_while(2, n);
        chk(n == 3 * B, "R4 gap length", n, 3 * B);
        chk(state == 2'd3 && frame_go, "R5 frame grant", int'(state), 3);
        step(2);
        chk(frame_go, "R5 grant held", int'(frame_go), 1);
        done = 1'b1; @(negedge clk); done = 1'b0;
        chk(state == 2'd1, "R5 jam resumes after done", int'(state), 1);

        pulse_req();
        count_while(1, n);
        count_while(2, n);
        chk(state == 2'd3, "R6 frame before abort", int'(state), 3);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk(state == 2'd1, "R6 jam resumes after abort", int'(state), 1);

        // first clock of a jam byte: clear enable, byte must still complete
        en = 1'b0;
        count_while(1, n);
        chk(n == B, "R7 jam byte finished", n, B);
        chk(state == 2'd0 && !tx_valid, "R7 idle after enable clear", int'(state), 0);

        gap = 7'd0;
        pulse_req();
        chk(state == 2'd2, "R9 idle request to gap", int'(state), 2);
        count_while(2, n);
        chk(n == B, "R4 zero gap as one byte", n, B);
        chk(state == 2'd3, "R9 frame without jam", int'(state), 3);
        done = 1'b1; @(negedge clk); done = 1'b0;
        chk(state == 2'd0, "R9 idle after frame", int'(state), 0);

        fd = 1'b1; en = 1'b1; gap = 7'd2;
        step(4);
        chk(state == 2'd0 && !tx_valid, "R8 no jam in full duplex", int'(state), 0);
        pulse_req();
        chk(state == 2'd2, "R8 request served", int'(state), 2);
        count_while(2, n);
        chk(n == 2 * B, "R8 gap length", n, 2 * B);
        done = 1'b1; @(negedge clk); done = 1'b0;
        chk(state == 2'd0, "R8 idle after frame", int'(state), 0);

        fd = 1'b0;
        step(1);
        chk(state == 2'd1, "R2 jam on return to half duplex", int'(state), 1);
        en = 1'b0;
        count_while(1, n);
        chk(state == 2'd0, "R7 final idle", int'(state), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule